// File: doc/BRIEF.md
# Sound-CPU Address Decoder with Banked Main-Bus Window

This block sits beside a small sound processor that issues 16-bit addresses and splits each access among the resources that processor can reach. Local work RAM (8 KB) appears twice, in two adjacent copies. A block of four FM synthesizer ports, a write-only bank register, a tone-generator (PSG) port with four address aliases, a read-only video status area and a 32 KB window onto a 24-bit main bus each get their own select. The RAM array, the sound chips and the main-bus arbiter are outside the block. They are driven from the one-hot select vector, the RAM index, the FM port number, the translated main-bus address and a wait-cycle count.

The bank register holds the nine upper bits of every main-bus address reached through the window. Software loads it one bit per write: bit 0 of the written data enters at the top and the older bits move down one place, so nine writes set a full bank value. An access that matches no region raises no select. Such a read returns all ones on a fill bus. Any such access pulses an error flag for one cycle, and a write to it changes nothing.

Top module: `snd_addr_decoder`

## Requirements
- R1: An access with address 0x0000-0x3FFF raises regionSel bit 0 (RAM), and ramIndex equals the address with bits 15..13 cleared, so 0x2000-0x3FFF reach the same words as 0x0000-0x1FFF.
- R2: An access with address 0x4000-0x5FFF raises regionSel bit 1 (FM), and fmPort equals address bits 1..0.
- R3: A write whose upper address byte is 0x60 raises regionSel bit 2 (bank). On that clock edge the 9-bit bank value becomes {data bit 0, old bank bits 8..1}.
- R4: A write whose address ANDed with 0xFFF9 equals 0x7F11 (0x7F11, 0x7F13, 0x7F15, 0x7F17) raises regionSel bit 3 (PSG).
- R5: An access with address 0x8000-0xFFFF raises regionSel bit 5 (window), and busAddr equals {bank, address bits 14..0}.
- R6: waitCycles is 3 for a window read, 2 for a read whose upper address byte is 0x7F (which raises regionSel bit 4, video), and 0 for every other access.
- R7: An access matching no region raises no select. When it is a read, rdFill is 0xFF, and rdFill is 0x00 in every other case. errFlag is high in the cycle after such an access and low after any other cycle.
- R8: Writes to unmapped addresses and reads from 0x60xx leave the bank value unchanged.
- R9: After reset the bank value is 0 and errFlag is low.
- R10: regionSel has at most one bit set and is all zero while accValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | Access present this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| accAddr | input | 16 | Sound-CPU address |
| accWData | input | 8 | Write data (bit 0 feeds the bank register) |
| regionSel | output | 6 | One-hot select: 0 RAM, 1 FM, 2 bank, 3 PSG, 4 video, 5 window |
| ramIndex | output | 13 | Mirrored RAM word index |
| fmPort | output | 2 | FM chip port number |
| busAddr | output | 24 | Main-bus address for the window |
| waitCycles | output | 2 | Extra wait cycles for this access |
| rdFill | output | 8 | 0xFF on an unmapped read, else 0x00 |
| errFlag | output | 1 | One-cycle pulse after an unmapped access |

## Verification
The selects, ramIndex, fmPort, busAddr, waitCycles and rdFill depend only on the inputs and the current bank value. The bench samples them a quarter period after it drives the inputs, in the same cycle. errFlag and the bank value change one clock edge later. The monitor therefore checks errFlag just after the rising edge that ends the access. A bank write shows up in busAddr on the next window access. For each driven access, the scoreboard queue holds the combinational expectations together with the delayed flag expectation, so no result is read in the wrong cycle.

// File: rtl/snd_dec_pkg.sv
package snd_dec_pkg;
  localparam int REGION_N = 6;

  typedef enum logic [2:0] {
    RG_RAM  = 3'd0,
    RG_FM   = 3'd1,
    RG_BANK = 3'd2,
    RG_PSG  = 3'd3,
    RG_VID  = 3'd4,
    RG_WIN  = 3'd5
  } region_e;

  typedef struct packed {
    logic [REGION_N-1:0] regionSel;
    logic                bankShift;
    logic                missHit;
    logic                missRead;
    logic                winRead;
    logic                vidRead;
  } decStrobe_t;
endpackage

// File: rtl/snd_dec_ctrl.sv
module snd_dec_ctrl
  import snd_dec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  output decStrobe_t        strobe
);
  localparam int PAGE_W = 8;
  localparam logic [PAGE_W-1:0] BANK_PAGE = 8'h60;
  localparam logic [PAGE_W-1:0] VID_PAGE  = 8'h7F;
  localparam logic [ADDR_W-1:0] PSG_MASK  = 16'hFFF9;
  localparam logic [ADDR_W-1:0] PSG_MATCH = 16'h7F11;

  logic [PAGE_W-1:0] page;
  logic isRam, isFm, isWin, isBankPage, isPsg, isVidPage;
  logic [REGION_N-1:0] hit;
  logic [REGION_N-1:0] sel;

  assign page       = accAddr[ADDR_W-1 -: PAGE_W];
  assign isRam      = (accAddr[ADDR_W-1 -: 2] == 2'b00);
  assign isFm       = (accAddr[ADDR_W-1 -: 3] == 3'b010);
  assign isWin      = accAddr[ADDR_W-1];
  assign isBankPage = (page == BANK_PAGE);
  assign isPsg      = ((accAddr & PSG_MASK) == PSG_MATCH);
  assign isVidPage  = (page == VID_PAGE);

  always_comb begin
    hit          = '0;
    hit[RG_RAM]  = isRam;
    hit[RG_FM]   = isFm;
    hit[RG_BANK] = accWrite & isBankPage;
    hit[RG_PSG]  = accWrite & isPsg;
    hit[RG_VID]  = ~accWrite & isVidPage;
    hit[RG_WIN]  = isWin;
  end

  genvar g;
  generate
    for (g = 0; g < REGION_N; g++) begin : g_sel
      assign sel[g] = accValid & hit[g];
    end
  endgenerate

  always_comb begin
    strobe.regionSel = sel;
    strobe.bankShift = sel[RG_BANK];
    strobe.missHit   = accValid & ~(|sel);
    strobe.missRead  = accValid & ~accWrite & ~(|sel);
    strobe.winRead   = sel[RG_WIN] & ~accWrite;
    strobe.vidRead   = sel[RG_VID];
  end
endmodule

// File: rtl/snd_dec_path.sv
module snd_dec_path
  import snd_dec_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int MAIN_W   = 24,
  parameter int RAM_W    = 13,
  parameter int WAIT_W   = 2,
  parameter int WIN_WAIT = 3,
  parameter int VID_WAIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  decStrobe_t        strobe,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] accWData,
  output logic [RAM_W-1:0]  ramIndex,
  output logic [1:0]        fmPort,
  output logic [MAIN_W-1:0] busAddr,
  output logic [WAIT_W-1:0] waitCycles,
  output logic [DATA_W-1:0] rdFill,
  output logic              errFlag
);
  localparam int WIN_W  = ADDR_W - 1;
  localparam int BANK_W = MAIN_W - WIN_W;

  logic [BANK_W-1:0] bankQ;
  logic [BANK_W-1:0] bankNext;

  assign bankNext = {accWData[0], bankQ[BANK_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ   <= '0;
      errFlag <= 1'b0;
    end else begin
      if (strobe.bankShift) bankQ <= bankNext;
      errFlag <= strobe.missHit;
    end
  end

  assign busAddr  = {bankQ, accAddr[WIN_W-1:0]};
  assign ramIndex = accAddr[RAM_W-1:0];
  assign fmPort   = accAddr[1:0];
  assign rdFill   = strobe.missRead ? {DATA_W{1'b1}} : '0;

  always_comb begin
    if (strobe.winRead)      waitCycles = WAIT_W'(WIN_WAIT);
    else if (strobe.vidRead) waitCycles = WAIT_W'(VID_WAIT);
    else                     waitCycles = '0;
  end
endmodule

// File: rtl/snd_addr_decoder.sv
module snd_addr_decoder
  import snd_dec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int MAIN_W = 24,
  parameter int RAM_W  = 13,
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] accWData,
  output logic [5:0]        regionSel,
  output logic [RAM_W-1:0]  ramIndex,
  output logic [1:0]        fmPort,
  output logic [MAIN_W-1:0] busAddr,
  output logic [WAIT_W-1:0] waitCycles,
  output logic [DATA_W-1:0] rdFill,
  output logic              errFlag
);
  decStrobe_t strobe;

  snd_dec_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .accValid(accValid),
    .accWrite(accWrite),
    .accAddr (accAddr),
    .strobe  (strobe)
  );

  snd_dec_path #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAIN_W(MAIN_W),
    .RAM_W(RAM_W), .WAIT_W(WAIT_W)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .accAddr   (accAddr),
    .accWData  (accWData),
    .ramIndex  (ramIndex),
    .fmPort    (fmPort),
    .busAddr   (busAddr),
    .waitCycles(waitCycles),
    .rdFill    (rdFill),
    .errFlag   (errFlag)
  );

  assign regionSel = strobe.regionSel;
endmodule

// File: rtl/snd_addr_decoder_chk.sv
module snd_addr_decoder_chk (
  input logic        clk,
  input logic        rstN,
  input logic        accValid,
  input logic        accWrite,
  input logic [15:0] accAddr,
  input logic [7:0]  accWData,
  input logic [5:0]  regionSel,
  input logic [23:0] busAddr,
  input logic [1:0]  waitCycles,
  input logic        errFlag
);
  logic bankWr;
  assign bankWr = accValid && accWrite && regionSel[2];

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regionSel));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> (regionSel == 6'd0));

  p_bank_shift_r3: assert property (@(posedge clk) disable iff (!rstN)
    bankWr |=> (busAddr[23:15] == {$past(accWData[0]), $past(busAddr[23:16])}));

  p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !bankWr |=> $stable(busAddr[23:15]));

  p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && regionSel == 6'd0) |=> errFlag);

  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(accValid && regionSel == 6'd0) |=> !errFlag);

  p_wait_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    (waitCycles != 2'd0) |-> (accValid && !accWrite));
endmodule

bind snd_addr_decoder snd_addr_decoder_chk u_chk (
  .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
  .accAddr(accAddr), .accWData(accWData), .regionSel(regionSel),
  .busAddr(busAddr), .waitCycles(waitCycles), .errFlag(errFlag)
);

// File: tb/snd_addr_decoder_bench.sv
module snd_addr_decoder_bench;
  localparam int CLK_P = 10;

  typedef struct {
    logic [5:0]  sel;
    logic [12:0] ramIdx;
    logic [1:0]  fmPort;
    logic [23:0] bus;
    logic        chkBus;
    logic [1:0]  waitC;
    logic [7:0]  fill;
    logic        err;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0, accWrite = 1'b0;
  logic [15:0] accAddr = '0;
  logic [7:0]  accWData = '0;
  logic [5:0]  regionSel;
  logic [12:0] ramIndex;
  logic [1:0]  fmPort;
  logic [23:0] busAddr;
  logic [1:0]  waitCycles;
  logic [7:0]  rdFill;
  logic        errFlag;

  int compared = 0, mismatched = 0;
  logic [8:0] bankModel = '0;
  expItem_t q[$];
  bit driveDone = 0;
  bit running = 0;

  always #(CLK_P/2) clk = ~clk;

  snd_addr_decoder u_snd_addr_decoder (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accAddr(accAddr), .accWData(accWData), .regionSel(regionSel),
    .ramIndex(ramIndex), .fmPort(fmPort), .busAddr(busAddr),
    .waitCycles(waitCycles), .rdFill(rdFill), .errFlag(errFlag)
  );

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected behaviour built from the requirement text.
  function automatic expItem_t model(logic v, logic w, logic [15:0] a, logic [8:0] bank);
    expItem_t e;
    e.sel = '0;
    e.ramIdx = a & 16'h1FFF;
    e.fmPort = a % 4;
    e.bus = {bank, a[14:0]};
    e.chkBus = 1'b0;
    e.waitC = 2'd0;
    if (v) begin
      if (a < 16'h4000) e.sel = 6'b000001;
      else if (a < 16'h6000) e.sel = 6'b000010;
      else if (a >= 16'h8000) begin
        e.sel = 6'b100000; e.chkBus = 1'b1;
        if (!w) e.waitC = 2'd3;
      end
      else if (w && a[15:8] == 8'h60) e.sel = 6'b000100;
      else if (w && (a == 16'h7F11 || a == 16'h7F13 || a == 16'h7F15 || a == 16'h7F17))
        e.sel = 6'b001000;
      else if (!w && a[15:8] == 8'h7F) begin e.sel = 6'b010000; e.waitC = 2'd2; end
    end
    e.err  = v && (e.sel == 0);
    e.fill = (v && !w && e.sel == 0) ? 8'hFF : 8'h00;
    return e;
  endfunction

  task automatic issue(logic v, logic w, logic [15:0] a, logic [7:0] d);
    expItem_t e;
    @(negedge clk);
    accValid = v; accWrite = w; accAddr = a; accWData = d;
    e = model(v, w, a, bankModel);
    q.push_back(e);
    if (v && w && a[15:8] == 8'h60) bankModel = {d[0], bankModel[8:1]};
  endtask

  initial begin : monitor
    expItem_t e;
    wait (running);
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (q.size() > 0) begin
        e = q.pop_front();
        cmp("R10/R1-region regionSel", regionSel, e.sel);
        if (e.sel[0]) cmp("R1 ramIndex", ramIndex, e.ramIdx);
        if (e.sel[1]) cmp("R2 fmPort", fmPort, e.fmPort);
        if (e.chkBus) cmp("R5 busAddr", busAddr, e.bus);
        cmp("R6 waitCycles", waitCycles, e.waitC);
        cmp("R7 rdFill", rdFill, e.fill);
        @(posedge clk); #1;
        cmp("R7 errFlag", errFlag, e.err);
      end
    end
  end

  initial begin : watchdog
    #(CLK_P * 20000);
    mismatched++; compared++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : driver
    logic [8:0] pat;
    repeat (3) @(negedge clk);
    // R9: reset state
    cmp("R9 errFlag after reset", errFlag, 1'b0);
    accValid = 1'b1; accAddr = 16'h8000; #1;
    cmp("R9 bank after reset", busAddr[23:15], 9'd0);
    accValid = 1'b0;
    @(negedge clk); rstN = 1'b1;
    running = 1;
    issue(0, 0, 16'h1234, 8'h00);          // R10 idle
    issue(1, 0, 16'h0000, 8'h00);          // R1
    issue(1, 0, 16'h1234, 8'h00);
    issue(1, 1, 16'h3FFF, 8'h55);          // R1 mirror
    issue(1, 0, 16'h2ABC, 8'h00);
    issue(1, 1, 16'h4002, 8'h11);          // R2
    issue(1, 0, 16'h5FFF, 8'h00);
    issue(1, 0, 16'h8000, 8'h00);          // R5/R6 window at bank 0
    pat = 9'h1A5;
    for (int i = 0; i < 9; i++) issue(1, 1, 16'h6000 + 16'(i), {7'd0, pat[i]}); // R3
    issue(1, 0, 16'h8123, 8'h00);          // R5 bank 0x1A5
    issue(1, 1, 16'hFFFF, 8'h00);          // R5 write, no wait
    issue(1, 1, 16'h60FF, 8'h00);          // R3 shift zero in
    issue(1, 0, 16'hC000, 8'h00);
    issue(1, 1, 16'h7F11, 8'h9F);          // R4
    issue(1, 1, 16'h7F13, 8'h00);
    issue(1, 1, 16'h7F15, 8'h00);
    issue(1, 1, 16'h7F17, 8'h00);
    issue(1, 1, 16'h7F19, 8'h00);          // R7 unmapped write
    issue(1, 1, 16'h7F10, 8'h00);
    issue(1, 0, 16'h7F04, 8'h00);          // R6 video read
    issue(1, 0, 16'h7F11, 8'h00);
    issue(1, 0, 16'h6000, 8'h01);          // R8 read of bank page
    issue(1, 1, 16'h6100, 8'h01);          // R8 unmapped write
    issue(1, 0, 16'h7000, 8'h00);          // R7 unmapped read
    issue(0, 0, 16'h7000, 8'h00);          // R7 flag drops
    issue(1, 0, 16'hABCD, 8'h00);          // R8 bank unchanged
    issue(0, 0, 16'h0000, 8'h00);
    repeat (4) @(negedge clk);
    driveDone = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule